// File: doc/BRIEF.md
# PHY Management Command Controller

This block runs PHY management transactions over a two-wire serial management bus (a clock, MDC, and a bidirectional data line, MDIO). Software sets up a whole access with register writes: for a write it first loads the 16-bit data register and then writes the control register with the PHY address, the register number and the write flag set. For a read it writes the control register with the write flag clear. That one control write launches the frame. Software then polls a busy bit in the control register. When the busy bit clears, a write has completed, or the value returned by a read sits in the data register.

Each frame is 64 MDC periods long. It has 32 preamble ones, the start pattern, the opcode, the PHY address, the register number, the turnaround and 16 data bits. All fields are sent most significant bit first. MDC is derived from the system clock. Its half period, counted in system clock cycles, comes from a divisor register, so the MDC period is always an even number of system clocks.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the busy bit reads 0, MDC is low, MDIO is not driven (output enable low, output low), the data register reads 0 and the divisor register reads 2.
- R2: The register map uses three addresses: 0 for control, 1 for data and 2 for divisor.
  - Control is {busy at bit 15, write flag at bit 10, PHY address at bits 9:5, register number at bits 4:0}.
  - Data holds 16 bits.
  - Divisor holds an 8-bit half period.
  - Reads of address 3 return 0.
- R3: A control write while idle sets busy in the next cycle. Busy stays set for exactly 128×H system clock cycles, where H is the effective half period.
- R4: While busy is set, writes to control, data and divisor are ignored.
- R5: The frame, in transmit order, is:
  - 32 ones;
  - the start pattern 0 then 1;
  - the opcode, 1 then 0 for a read or 0 then 1 for a write;
  - 5 PHY address bits;
  - 5 register number bits;
  - 2 turnaround bits;
  - 16 data bits.
  All multi-bit fields are sent MSB first.
- R6: In a write frame the controller drives MDIO for all 64 bits. The turnaround is 1 then 0, and the data bits are the data register contents.
- R7: In a read frame the controller releases MDIO from the first turnaround bit (bit 46) to the end of the frame. It samples MDIO on the 16 MDC rising edges of the data field. After busy clears, the data register holds the sampled 16-bit value, MSB first.
- R8: MDC stays low for H cycles and then high for H cycles per bit. H is the divisor value, and a divisor of 0 acts as 1. A frame has exactly 64 MDC rising edges.
- R9: MDC is low when idle. Driven MDIO values change only on MDC falling edges within a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The embedded assertions check four things on every cycle:
- a control write while idle starts a frame at bit 0 with MDC low;
- writes during busy leave the command and divisor untouched;
- MDC is low and MDIO is released while idle;
- MDIO output and the data register change only at the proper MDC edges.

The bench's scenarios show the rest. They cover the exact frame bit pattern, the turnaround and release point, the value a responding PHY returns, and the frame length under several divisor values including 0. A behavioural reference model is compared against every output on every clock. Separate checks confirm the captured frame, the returned read value and the rising-edge count.

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl #(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_BITS = 64;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;

  logic                  busy, wr_op, mdc_q;
  logic [4:0]            phy_q, reg_q;
  logic [15:0]           data_q;
  logic [DIV_W-1:0]      half_q, hcnt, half_eff;
  logic [BIT_W-1:0]      bitn;
  logic [FRAME_BITS-1:0] sh;

  assign half_eff = (half_q == '0) ? DIV_W'(1) : half_q;
  assign mdc      = mdc_q;
  assign mdio_oe  = busy && (wr_op || bitn < BIT_W'(TA_POS));
  assign mdio_o   = mdio_oe & sh[FRAME_BITS-1];

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {busy, 4'b0, wr_op, phy_q, reg_q};
      2'd1:    rd_data = data_q;
      2'd2:    rd_data = 16'(half_q);
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      wr_op  <= 1'b0;
      mdc_q  <= 1'b0;
      phy_q  <= '0;
      reg_q  <= '0;
      data_q <= '0;
      half_q <= DIV_W'(DIV_RESET);
      hcnt   <= '0;
      bitn   <= '0;
      sh     <= '0;
    end else if (!busy) begin
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            wr_op <= wr_data[10];
            phy_q <= wr_data[9:5];
            reg_q <= wr_data[4:0];
            busy  <= 1'b1;
            mdc_q <= 1'b0;
            hcnt  <= '0;
            bitn  <= '0;
            sh    <= {32'hFFFF_FFFF, 2'b01,
                      wr_data[10] ? 2'b01 : 2'b10,
                      wr_data[9:5], wr_data[4:0],
                      wr_data[10] ? 2'b10 : 2'b00, data_q};
          end
          2'd1: data_q <= wr_data;
          2'd2: half_q <= wr_data[DIV_W-1:0];
          default: ;
        endcase
      end
    end else if (hcnt == half_eff - DIV_W'(1)) begin
      hcnt <= '0;
      if (!mdc_q) begin
        mdc_q <= 1'b1;
        if (!wr_op && bitn >= BIT_W'(DATA_POS))
          data_q <= {data_q[14:0], mdio_i};
      end else begin
        mdc_q <= 1'b0;
        if (bitn == BIT_W'(FRAME_BITS-1)) begin
          busy <= 1'b0;
        end else begin
          bitn <= bitn + BIT_W'(1);
          sh   <= {sh[FRAME_BITS-2:0], 1'b0};
        end
      end
    end else begin
      hcnt <= hcnt + DIV_W'(1);
    end
  end

  a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && wr_addr == 2'd0) |=> (busy && bitn == '0 && !mdc_q));

  a_r4_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable({wr_op, phy_q, reg_q, half_q}));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc_q && !mdio_oe));

  a_r9_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(mdc_q)) |-> $stable(mdio_o));

  a_r7_sample_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$rose(mdc_q)) |-> $stable(data_q));
endmodule

// File: tb/sim_mdio_cmd_ctrl.sv
module sim_mdio_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b0;

  always #10 clk = ~clk;

  mdio_cmd_ctrl u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  int vectors = 0, fails = 0, cyc = 0;

  // behavioural reference model
  bit        m_busy, m_wr;
  bit [4:0]  m_phy, m_reg;
  bit [15:0] m_data;
  bit [7:0]  m_half;
  bit [63:0] m_frame;
  int        m_t;

  function automatic int eff_h();
    return (m_half == 0) ? 1 : int'(m_half);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_wr = 0; m_phy = 0; m_reg = 0; m_data = 0; m_half = 2; m_t = 0;
    end else if (m_busy) begin
      if ((m_t % (2*eff_h())) == eff_h()-1 && !m_wr && (m_t/(2*eff_h())) >= 48)
        m_data = {m_data[14:0], mdio_i};
      m_t++;
      if (m_t == 128*eff_h()) m_busy = 0;
    end else if (wr_en) begin
      if (wr_addr == 0) begin
        m_wr = wr_data[10]; m_phy = wr_data[9:5]; m_reg = wr_data[4:0];
        m_frame = {32'hFFFF_FFFF, 2'b01, m_wr ? 2'b01 : 2'b10, m_phy, m_reg,
                   m_wr ? 2'b10 : 2'b00, m_data};
        m_busy = 1; m_t = 0;
      end else if (wr_addr == 1) m_data = wr_data;
      else if (wr_addr == 2) m_half = wr_data[7:0];
    end
  end

  always @(posedge clk) rd_addr <= (rd_addr == 2'd3) ? 2'd0 : rd_addr + 2'd1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic exp_mdc, exp_oe, exp_o;
      logic [15:0] exp_rd;
      int b;
      b       = m_busy ? m_t/(2*eff_h()) : 0;
      exp_mdc = m_busy && ((m_t % (2*eff_h())) >= eff_h());
      exp_oe  = m_busy && (m_wr || b < 46);
      exp_o   = exp_oe && m_frame[63-b];
      case (rd_addr)
        2'd0: exp_rd = {m_busy, 4'b0, m_wr, m_phy, m_reg};
        2'd1: exp_rd = m_data;
        2'd2: exp_rd = {8'b0, m_half};
        default: exp_rd = 16'h0;
      endcase
      chk("R8 mdc", 64'(mdc), 64'(exp_mdc));
      chk("R6/R7 mdio_oe", 64'(mdio_oe), 64'(exp_oe));
      chk("R5 mdio_o", 64'(mdio_o), 64'(exp_o));
      chk("R2 rd_data", 64'(rd_data), 64'(exp_rd));
    end
  end

  // PHY responder and frame capture, driven only by pins
  int        phy_cnt;
  bit [15:0] phy_resp;
  bit [63:0] cap;
  always @(posedge mdc) begin
    cap = {cap[62:0], mdio_o};
    phy_cnt++;
    if (phy_cnt >= 48 && phy_cnt < 64) mdio_i <= phy_resp[63-phy_cnt];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic wreg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    while (rd_addr != a) @(negedge clk);
    v = rd_data;
  endtask

  task automatic finish_frame();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] resp);
    logic [15:0] v;
    phy_resp = resp; phy_cnt = 0; cap = 0;
    wreg(0, {5'b0, 1'b0, phy, rg});
    finish_frame();
    rreg(1, v);
    chk("R7 read result", 64'(v), 64'(resp));
    chk("R8 rising edges", 64'(phy_cnt), 64'd64);
    chk("R5 read header", 64'(cap[63:18]), 64'({32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg}));
  endtask

  initial begin
    logic [15:0] v;
    int t0;
    repeat (3) @(negedge clk);
    chk("R1 mdc", 64'(mdc), 64'd0);
    chk("R1 mdio_oe", 64'(mdio_oe), 64'd0);
    chk("R1 mdio_o", 64'(mdio_o), 64'd0);
    rst_n = 1;
    rreg(0, v); chk("R1 busy", 64'(v[15]), 64'd0);
    rreg(1, v); chk("R1 data", 64'(v), 64'd0);
    rreg(2, v); chk("R1 divisor", 64'(v), 64'd2);
    rreg(3, v); chk("R2 unused addr", 64'(v), 64'd0);

    // write frame, H=2
    wreg(1, 16'hBEEF);
    phy_cnt = 0; cap = 0;
    wreg(0, {5'b0, 1'b1, 5'h11, 5'h03});
    t0 = cyc;
    // writes while busy must be ignored
    wreg(0, {5'b0, 1'b0, 5'h02, 5'h1C});
    wreg(1, 16'h1234);
    wreg(2, 16'h0005);
    finish_frame();
    chk("R3 busy length", 64'(cyc - t0), 64'(128*2 + 1));
    chk("R5/R6 write frame", cap,
        {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h11, 5'h03, 2'b10, 16'hBEEF});
    chk("R8 rising edges", 64'(phy_cnt), 64'd64);
    rreg(0, v); chk("R4 ctrl unchanged", 64'(v), 64'({5'b0, 1'b1, 5'h11, 5'h03}));
    rreg(1, v); chk("R4 data unchanged", 64'(v), 64'h BEEF);
    rreg(2, v); chk("R4 divisor unchanged", 64'(v), 64'd2);

    // read frames under several divisors
    wreg(2, 16'd3);
    do_read(5'h01, 5'h02, 16'hA5C3);
    wreg(2, 16'd0);
    do_read(5'h1F, 5'h1F, 16'h8001);
    wreg(2, 16'd1);
    do_read(5'h0A, 5'h15, 16'h7FFE);
    wreg(1, 16'h00FF);
    phy_cnt = 0; cap = 0;
    wreg(0, {5'b0, 1'b1, 5'h00, 5'h00});
    finish_frame();
    chk("R6 write frame H1", cap,
        {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h00, 5'h00, 2'b10, 16'h00FF});
    chk("R9 idle mdc", 64'(mdc), 64'd0);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule